// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream from a three-wire serial audio port (a bit clock, a word clock marking the channel, and one data line) and turns it into one parallel pair of 24-bit samples per frame. The pair appears with a one-cycle valid strobe for the interpolation path that follows. All three port lines are brought into the system-clock domain through register synchronizers. The block then finds the rising edges of the bit clock and assembles each channel word in one of four framings: left-justified, I2S, right-justified 16-bit and right-justified 24-bit.

Channel boundaries come only from word-clock changes seen at bit-clock rising edges. Slots of unequal length are therefore accepted. A speed-mode input sets the longest channel slot the port may carry. Bits past that length are dropped. Short right-justified words are sign-extended to the full output width.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame completes, `valid_o` is 0 and `left_o` and `right_o` are 0.
- R2: With `fmt_i` = 0 (left-justified), word clock high marks the left channel. The MSB is the bit taken at the first bit-clock rise of a slot, and bits past the 24th of a slot are ignored.
- R3: With `fmt_i` = 1 (I2S), word clock low marks the left channel. The bit at the first rise of a slot is ignored, the MSB is the bit at the second rise, and bits past the 25th are ignored.
- R4: With `fmt_i` = 2, word clock high marks the left channel. The word is the last 16 bits of the slot, MSB first, sign-extended from bit 15 to 24 bits.
- R5: With `fmt_i` = 3, word clock high marks the left channel. The word is the last 24 bits of the slot, MSB first.
- R6: `valid_o` is a single-cycle pulse, raised once per frame after the right slot ends, that is, when the next word-clock change is seen. `left_o` and `right_o` change only in a cycle where `valid_o` is 1.
- R7: Slot boundaries follow word-clock changes only, so left and right slots of different bit counts each decode correctly.
- R8: A slot that began before the first word-clock change after reset is discarded. A right slot not preceded by a complete left slot produces no output.
- R9: The bits taken per slot are limited by `speed_i`: 128 for code 0, 64 for code 1, and 32 for codes 2 and 3. Later bits in the slot are discarded and shift nothing into the word.
- R10: In left-justified format, a slot shorter than 24 bits yields its bits left-aligned, with the unused low bits 0.
- R11: The system clock runs at least four times the bit-clock rate. Exactly one data bit is taken per bit-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial port |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| wclk_i | input | 1 | Word (channel select) clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| fmt_i | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified 16, 3 right-justified 24 |
| speed_i | input | 2 | Rate mode: 0 single, 1 double, 2 and 3 quad |
| left_o | output | 24 | Left sample of the last completed frame |
| right_o | output | 24 | Right sample of the last completed frame |
| valid_o | output | 1 | One-cycle strobe: a new pair is on the outputs |

## Verification
On every cycle the assertions check several invariants: a bit-clock edge yields a single bit strobe, the valid strobe never lasts two cycles, the sample outputs hold between strobes, the slot bit counter never passes the limit for the speed mode, and 16-bit words leave with their sign copied into the top byte. Whether the right bits land in the right positions can only be shown by the bench scenarios. Those scenarios drive each framing, uneven and short slots, slots longer than the speed limit, and partial slots after reset. The bench decodes each transmitted bit stream itself and compares the result with every strobe.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   typedef enum logic [1:0] {
      FMT_LJ   = 2'd0,
      FMT_I2S  = 2'd1,
      FMT_RJ16 = 2'd2,
      FMT_RJ24 = 2'd3
   } fmt_e;

   // Word-clock level that marks the left channel for a framing
   function automatic logic left_level(input fmt_e f);
      return (f == FMT_I2S) ? 1'b0 : 1'b1;
   endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic wclk_i,
   input  logic sdata_i,
   output logic bit_stb_o,
   output logic wsel_o,
   output logic dbit_o
);

   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] b_q, w_q, d_q;
   logic              b_last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pcm_rx_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  b_q[0] <= 1'b0;
                  w_q[0] <= 1'b0;
                  d_q[0] <= 1'b0;
               end else begin
                  b_q[0] <= bclk_i;
                  w_q[0] <= wclk_i;
                  d_q[0] <= sdata_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  b_q[g] <= 1'b0;
                  w_q[g] <= 1'b0;
                  d_q[g] <= 1'b0;
               end else begin
                  b_q[g] <= b_q[g-1];
                  w_q[g] <= w_q[g-1];
                  d_q[g] <= d_q[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) b_last_q <= 1'b0;
      else        b_last_q <= b_q[LAST];
   end

   assign bit_stb_o = b_q[LAST] & ~b_last_q;
   assign wsel_o    = w_q[LAST];
   assign dbit_o    = d_q[LAST];

   // R11: one bit-clock edge yields one strobe
   p_one_bit_per_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb_o |=> !bit_stb_o);

endmodule

// File: rtl/pcm_rx_word.sv
module pcm_rx_word
   import pcm_rx_pkg::*;
#(
   parameter int WORD_W  = 24,
   parameter int SHORT_W = 16,
   parameter int IDX_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              take_i,
   input  logic              dbit_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  fmt_e              fmt_i,
   output logic [WORD_W-1:0] word_o
);

   localparam int EXT_W = WORD_W - SHORT_W;

   fmt_e              fmt_q;
   logic [WORD_W-1:0] pos_q;   // position-indexed word (left-justified, I2S)
   logic [WORD_W-1:0] sh_q;    // running shifter (right-justified)
   logic [IDX_W-1:0]  slot_pos;

   generate
      if (SHORT_W >= WORD_W) begin : g_bad_short
         $error("pcm_rx_word: SHORT_W must be below WORD_W");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("pcm_rx_word: WORD_W too small");
      end
   endgenerate

   assign slot_pos = (fmt_q == FMT_I2S) ? idx_i - IDX_W'(1) : idx_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q <= FMT_LJ;
         pos_q <= '0;
         sh_q  <= '0;
      end else if (start_i) begin
         fmt_q <= fmt_i;
         sh_q  <= {{(WORD_W-1){1'b0}}, dbit_i};
         pos_q <= (fmt_i == FMT_LJ) ? {dbit_i, {(WORD_W-1){1'b0}}} : '0;
      end else if (take_i) begin
         sh_q <= {sh_q[WORD_W-2:0], dbit_i};
         for (int k = 0; k < WORD_W; k++) begin
            if (slot_pos == IDX_W'(WORD_W-1-k)) pos_q[k] <= dbit_i;
         end
      end
   end

   always_comb begin
      unique case (fmt_q)
         FMT_RJ16: word_o = {{EXT_W{sh_q[SHORT_W-1]}}, sh_q[SHORT_W-1:0]};
         FMT_RJ24: word_o = sh_q;
         default:  word_o = pos_q;
      endcase
   end

endmodule

// File: rtl/pcm_rx_deframe.sv
module pcm_rx_deframe
   import pcm_rx_pkg::*;
#(
   parameter int WORD_W   = 24,
   parameter int SHORT_W  = 16,
   parameter int MAX_SLOT = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb_i,
   input  logic              wsel_i,
   input  logic              dbit_i,
   input  fmt_e              fmt_i,
   input  logic [1:0]        spd_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o
);

   localparam int IDX_W  = $clog2(MAX_SLOT + 1);
   localparam int LIM_SS = MAX_SLOT;
   localparam int LIM_DS = MAX_SLOT / 2;
   localparam int LIM_QS = MAX_SLOT / 4;

   generate
      if (LIM_QS < WORD_W + 1) begin : g_bad_slot
         $error("pcm_rx_deframe: MAX_SLOT too short for quad-speed framing");
      end
   endgenerate

   logic              have_ref_q, w_prev_q, in_slot_q, slot_left_q, left_ok_q;
   logic [IDX_W-1:0]  idx_q, limit;
   logic [WORD_W-1:0] left_hold_q, word;
   logic              boundary, take;

   always_comb begin
      unique case (spd_i)
         2'd0:    limit = IDX_W'(LIM_SS);
         2'd1:    limit = IDX_W'(LIM_DS);
         default: limit = IDX_W'(LIM_QS);
      endcase
   end

   assign boundary = bit_stb_i && have_ref_q && (wsel_i != w_prev_q);
   assign take     = bit_stb_i && in_slot_q && !boundary && (idx_q < limit);

   pcm_rx_word #(
      .WORD_W (WORD_W),
      .SHORT_W(SHORT_W),
      .IDX_W  (IDX_W)
   ) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(boundary),
      .take_i (take),
      .dbit_i (dbit_i),
      .idx_i  (idx_q),
      .fmt_i  (fmt_i),
      .word_o (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_ref_q  <= 1'b0;
         w_prev_q    <= 1'b0;
         in_slot_q   <= 1'b0;
         slot_left_q <= 1'b0;
         left_ok_q   <= 1'b0;
         idx_q       <= '0;
         left_hold_q <= '0;
         valid_o     <= 1'b0;
         left_o      <= '0;
         right_o     <= '0;
      end else begin
         valid_o <= 1'b0;
         if (bit_stb_i && !have_ref_q) begin
            have_ref_q <= 1'b1;
            w_prev_q   <= wsel_i;
         end
         if (boundary) begin
            w_prev_q    <= wsel_i;
            in_slot_q   <= 1'b1;
            idx_q       <= IDX_W'(1);
            slot_left_q <= (wsel_i == left_level(fmt_i));
            if (in_slot_q && slot_left_q) begin
               left_hold_q <= word;
               left_ok_q   <= 1'b1;
            end else begin
               left_ok_q <= 1'b0;
               if (in_slot_q && left_ok_q) begin
                  left_o  <= left_hold_q;
                  right_o <= word;
                  valid_o <= 1'b1;
               end
            end
         end else if (take) begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   // R9: slot bit count stays within the speed-mode limit
   p_slot_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= limit);

   // R6: strobe lasts one cycle
   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6: samples hold between strobes
   p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcm_rx_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int SHORT_W     = 16,
   parameter int MAX_SLOT    = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_i,
   input  logic              wclk_i,
   input  logic              sdata_i,
   input  logic [1:0]        fmt_i,
   input  logic [1:0]        speed_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o
);

   localparam int EXT_W = WORD_W - SHORT_W;

   logic bit_stb, wsel, dbit;

   pcm_rx_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_i   (bclk_i),
      .wclk_i   (wclk_i),
      .sdata_i  (sdata_i),
      .bit_stb_o(bit_stb),
      .wsel_o   (wsel),
      .dbit_o   (dbit)
   );

   pcm_rx_deframe #(
      .WORD_W  (WORD_W),
      .SHORT_W (SHORT_W),
      .MAX_SLOT(MAX_SLOT)
   ) u_deframe (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_stb_i(bit_stb),
      .wsel_i   (wsel),
      .dbit_i   (dbit),
      .fmt_i    (fmt_e'(fmt_i)),
      .spd_i    (speed_i),
      .valid_o  (valid_o),
      .left_o   (left_o),
      .right_o  (right_o)
   );

   // R4: a 16-bit word leaves with its sign in the top bits
   p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && fmt_i == 2'd2 && $past(fmt_i) == 2'd2) |->
         (left_o[WORD_W-1:SHORT_W]  == {EXT_W{left_o[SHORT_W-1]}} &&
          right_o[WORD_W-1:SHORT_W] == {EXT_W{right_o[SHORT_W-1]}}));

endmodule

// File: tb/tb_pcm_serial_rx.sv
module tb_pcm_serial_rx;

   localparam int H = 4;   // system clocks per bit-clock half period

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
   logic [1:0]  fmt = 2'd0, spd = 2'd0;
   logic [23:0] left_o, right_o;
   logic        valid_o;

   always #5 clk = ~clk;

   pcm_serial_rx dut (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sdata),
      .fmt_i(fmt), .speed_i(spd), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   int checks = 0, errors = 0;
   logic [23:0] exp_l[$], exp_r[$];
   string       exp_tag[$];
   logic [23:0] last_l = '0, last_r = '0;
   logic        prev_valid = 1'b0;

   task automatic fail(input string req, input logic [23:0] act, input logic [23:0] exp);
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
   endtask

   // Per-clock comparison against the expected frame queue
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (valid_o) begin
            if (prev_valid) fail("R6 strobe longer than one cycle", 24'd1, 24'd0);
            if (exp_l.size() == 0) begin
               fail("R6/R8 unexpected strobe", left_o, 24'd0);
            end else begin
               checks++;
               if (left_o !== exp_l[0])  fail({exp_tag[0], " left"},  left_o,  exp_l[0]);
               if (right_o !== exp_r[0]) fail({exp_tag[0], " right"}, right_o, exp_r[0]);
               void'(exp_l.pop_front());
               void'(exp_r.pop_front());
               void'(exp_tag.pop_front());
            end
         end else if (left_o !== last_l || right_o !== last_r) begin
            fail("R6 outputs changed without strobe", left_o, last_l);
         end
         last_l = left_o;
         last_r = right_o;
         prev_valid = valid_o;
      end
   end

   function automatic int lim_of(input logic [1:0] s);
      return (s == 2'd0) ? 128 : (s == 2'd1) ? 64 : 32;
   endfunction

   // Transmit-side bit sequence of one slot
   task automatic make_bits(input logic [1:0] f, input logic [23:0] w, input int n, output bit q[$]);
      q = {};
      for (int i = 0; i < n; i++) begin
         bit b = 1'b1;
         case (f)
            2'd0: if (i < 24) b = w[23-i];
            2'd1: if (i >= 1 && i <= 24) b = w[24-i];
            2'd2: if (i >= n-16) b = w[15-(i-(n-16))];
            default: if (i >= n-24) b = w[23-(i-(n-24))];
         endcase
         q.push_back(b);
      end
   endtask

   // Receive-side expectation from the requirements
   function automatic logic [23:0] decode(input logic [1:0] f, input bit q[$], input int lim);
      logic [23:0] r = '0;
      int m = (q.size() < lim) ? q.size() : lim;
      case (f)
         2'd0: for (int p = 0; p < m && p < 24; p++) r[23-p] = q[p];       // R2 R10
         2'd1: for (int p = 1; p < m && p < 25; p++) r[24-p] = q[p];       // R3
         2'd2: begin                                                        // R4
            logic [15:0] a = '0;
            for (int p = 0; p < m; p++) a = {a[14:0], q[p]};
            r = {{8{a[15]}}, a};
         end
         default: for (int p = 0; p < m; p++) r = {r[22:0], q[p]};         // R5
      endcase
      return r;
   endfunction

   task automatic send_bit(input logic w, input logic d);
      bclk = 1'b0; wclk = w; sdata = d;
      repeat (H) @(negedge clk);
      bclk = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic send_slot(input logic w, input bit q[$]);
      foreach (q[i]) send_bit(w, q[i]);
   endtask

   task automatic idle_slot(input logic w, input int n);
      for (int i = 0; i < n; i++) send_bit(w, 1'b1);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bclk = 1'b0;
      repeat (4) @(negedge clk);
      checks++;
      if (valid_o !== 1'b0 || left_o !== '0 || right_o !== '0)
         fail("R1 reset state", left_o | right_o | {23'd0, valid_o}, 24'd0);
      exp_l = {}; exp_r = {}; exp_tag = {};
      last_l = '0; last_r = '0; prev_valid = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic run(input logic [1:0] f, input logic [1:0] s, input int frames,
                      input int nl, input int nr, input bit lead_left, input string tag);
      logic lv = (f == 2'd1) ? 1'b0 : 1'b1;
      do_reset();
      fmt = f; spd = s;
      if (lead_left) begin
         idle_slot(lv, 5);        // R8: partial left slot before any boundary
         idle_slot(!lv, 32);      // right slot with no complete left: no output
      end else begin
         idle_slot(!lv, 3);
      end
      for (int k = 0; k < frames; k++) begin
         bit ql[$], qr[$];
         logic [23:0] wl = (k == 0) ? 24'h800001 : 24'($urandom);
         logic [23:0] wr = (k == 0) ? 24'h7FFF80 : 24'($urandom);
         make_bits(f, wl, nl, ql);
         make_bits(f, wr, nr, qr);
         send_slot(lv, ql);
         send_slot(!lv, qr);
         exp_l.push_back(decode(f, ql, lim_of(s)));
         exp_r.push_back(decode(f, qr, lim_of(s)));
         exp_tag.push_back(tag);
      end
      idle_slot(lv, 3);
      repeat (30) @(negedge clk);
      checks++;
      if (exp_l.size() != 0) fail({tag, " R6 frames not delivered"}, 24'(exp_l.size()), 24'd0);
   endtask

   initial begin
      run(2'd0, 2'd0, 4, 32, 32, 1'b0, "R2 left-justified R11");
      run(2'd1, 2'd0, 4, 32, 32, 1'b0, "R3 I2S");
      run(2'd2, 2'd0, 4, 32, 32, 1'b0, "R4 right-justified 16");
      run(2'd3, 2'd0, 4, 32, 32, 1'b0, "R5 right-justified 24");
      run(2'd0, 2'd0, 3, 30, 34, 1'b1, "R7 R8 uneven slots after partial slot");
      run(2'd3, 2'd1, 3, 26, 40, 1'b0, "R7 uneven right-justified");
      run(2'd0, 2'd0, 3, 20, 20, 1'b0, "R10 short left-justified slot");
      run(2'd3, 2'd2, 3, 40, 40, 1'b0, "R9 quad-speed limit");
      run(2'd2, 2'd1, 2, 70, 70, 1'b0, "R9 double-speed limit");
      run(2'd1, 2'd3, 3, 36, 36, 1'b0, "R9 code 3 acts as quad");
      run(2'd3, 2'd0, 2, 100, 100, 1'b0, "R9 single-speed long slot");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule